// File: doc/BRIEF.md
# Trap Entry State Controller

This block computes the architectural state a processor core adopts when it takes a trap. A trap request arrives with a trap type and with the current trap level, processor-state word, hyper-state word, global register level, window pointer and count of savable windows. The block decides where the trap goes: privileged mode, hyperprivileged mode, RED state or error state. It then produces the next value of each of those registers.

Every result is registered. One clock after the request the outputs carry the new register values, a two-bit destination code and a one-cycle done pulse. The core writes them back into its register file. Between requests the outputs hold the last result.

Vector address formation, the trap stack and instruction fetch belong to neighbouring logic.

Top module: `trap_entry_ctrl`

## Requirements
- R1: When hyper-state bit 5 is set, or the trap level equals MAX_TL-1, the destination is RED (code 2'b10). This check has the highest priority.
- R2: Otherwise, when the trap level equals MAX_TL, the destination is error (code 2'b11). The trap-level, global-level, processor-state, hyper-state and window-pointer outputs equal the inputs sampled with the request, and the trap-type output keeps its previous value.
- R3: Otherwise, when the trap level exceeds MAX_PTL and the current mode is not hyperprivileged, the destination is hyperprivileged (code 2'b01). This is the guest-watchdog case. The mode is hyperprivileged when hyper-state bit 2 is set, privileged when only processor-state bit 2 is set, and user otherwise.
- R4: Otherwise, the destination is hyperprivileged (2'b01) when the mode is hyperprivileged, or when the mode is privileged and the trap type is 384 or more. In every remaining case the destination is privileged (2'b00).
- R5: For every destination except error, the trap level becomes TL+1, saturating at MAX_TL, and the trap-type output takes the request's trap type.
- R6: The global level becomes min(GL+1, MAX_PGL) for a privileged destination, and min(GL+1, MAX_GL) for a hyperprivileged or RED destination.
- R7: For every destination except error, processor-state bit 4 is set and bit 3 is cleared. Bit 2 is set for a privileged destination and cleared otherwise. All other bits pass through unchanged.
- R8: For a hyperprivileged destination, hyper-state bit 5 is cleared and bit 2 is set. For RED, bits 5 and 2 are both set. For a privileged destination, the hyper-state passes through unchanged.
- R9: For every destination except error, the window pointer changes according to the trap type, modulo NWIN:
  - type 0x24 adds 1;
  - types 0x80 to 0xBF add CANSAVE+2;
  - types 0xC0 to 0xFF subtract 1;
  - any other type leaves it unchanged.
- R10: done_o is high for exactly the cycle after each request. Without a request the outputs hold their values, whatever the inputs do.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Trap request, one cycle |
| tt_i | input | 9 | Trap type of the request |
| tl_i | input | 3 | Current trap level |
| pstate_i | input | 12 | Current processor-state word |
| hpstate_i | input | 12 | Current hyper-state word |
| gl_i | input | 2 | Current global register level |
| cwp_i | input | 3 | Current window pointer |
| cansave_i | input | 3 | Current count of savable windows |
| tl_o | output | 3 | Next trap level |
| tt_o | output | 9 | Next saved trap type |
| gl_o | output | 2 | Next global register level |
| pstate_o | output | 12 | Next processor-state word |
| hpstate_o | output | 12 | Next hyper-state word |
| cwp_o | output | 3 | Next window pointer |
| dest_o | output | 2 | Destination: 00 privileged, 01 hyperprivileged, 10 RED, 11 error |
| done_o | output | 1 | One-cycle pulse marking valid outputs |

## Verification
The guest-watchdog path is the hardest case to reach. It needs a trap level above MAX_PTL but below MAX_TL-1, a non-hyperprivileged mode and a clear RED bit; with the default parameters only levels 3 and 4 qualify. The bench drives both of those levels, from user mode and from privileged mode. It places the RED-by-level and error cases right next to them, so that a priority slip between neighbouring levels shows up.

The error case is also exercised right after a RED entry. This proves that the saved trap type is kept from the earlier trap rather than taken from the request.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    typedef enum logic [1:0] {
        DEST_PRIV = 2'b00,
        DEST_HYP  = 2'b01,
        DEST_RED  = 2'b10,
        DEST_ERR  = 2'b11
    } trap_dest_e;

    typedef enum logic [1:0] {
        MODE_USER = 2'b00,
        MODE_PRIV = 2'b01,
        MODE_HYP  = 2'b10
    } run_mode_e;

    // bit positions the core's state decoder relies on
    localparam int PS_PRIV_BIT  = 2;
    localparam int PS_AM_BIT    = 3;
    localparam int PS_ENTRY_BIT = 4;
    localparam int HS_HPRIV_BIT = 2;
    localparam int HS_RED_BIT   = 5;

    // first trap type that a privileged-mode trap hands to the hypervisor
    localparam int HYP_TT_FLOOR = 384;

endpackage

// File: rtl/trap_level_sat.sv
module trap_level_sat #(
    parameter int W     = 3,
    parameter int LIMIT = 6
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] val_o
);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    always_comb begin
        if (val_i >= LIM) begin
            val_o = LIM;
        end else begin
            val_o = val_i + W'(1);
        end
    end

endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
    import trap_entry_pkg::*;
#(
    parameter int TT_W    = 9,
    parameter int TL_W    = 3,
    parameter int MAX_TL  = 6,
    parameter int MAX_PTL = 2
) (
    input  logic [TT_W-1:0] tt_i,
    input  logic [TL_W-1:0] tl_i,
    input  logic            ps_priv_i,
    input  logic            hs_hpriv_i,
    input  logic            hs_red_i,
    output run_mode_e       mode_o,
    output trap_dest_e      dest_o
);
    localparam logic [TL_W-1:0] TL_RED_LVL = TL_W'(MAX_TL - 1);
    localparam logic [TL_W-1:0] TL_ERR_LVL = TL_W'(MAX_TL);
    localparam logic [TL_W-1:0] TL_PRIV_LIM = TL_W'(MAX_PTL);
    localparam logic [TT_W-1:0] TT_HYP_MIN = TT_W'(HYP_TT_FLOOR);

    always_comb begin
        if (hs_hpriv_i) begin
            mode_o = MODE_HYP;
        end else if (ps_priv_i) begin
            mode_o = MODE_PRIV;
        end else begin
            mode_o = MODE_USER;
        end
    end

    always_comb begin
        if (hs_red_i || (tl_i == TL_RED_LVL)) begin
            dest_o = DEST_RED;
        end else if (tl_i == TL_ERR_LVL) begin
            dest_o = DEST_ERR;
        end else if ((tl_i > TL_PRIV_LIM) && (mode_o != MODE_HYP)) begin
            dest_o = DEST_HYP;
        end else if ((mode_o == MODE_HYP) ||
                     ((mode_o == MODE_PRIV) && (tt_i >= TT_HYP_MIN))) begin
            dest_o = DEST_HYP;
        end else begin
            dest_o = DEST_PRIV;
        end
    end

endmodule

// File: rtl/trap_window_adj.sv
module trap_window_adj #(
    parameter int NWIN  = 8,
    parameter int TT_W  = 9,
    parameter int CWP_W = $clog2(NWIN)
) (
    input  logic [TT_W-1:0]  tt_i,
    input  logic [CWP_W-1:0] cwp_i,
    input  logic [CWP_W-1:0] cansave_i,
    output logic [CWP_W-1:0] cwp_o
);
    localparam int SUM_W = CWP_W + 2;
    localparam logic [TT_W-1:0] TT_CLEAN   = TT_W'(8'h24);
    localparam logic [TT_W-1:0] TT_SPILL_L = TT_W'(8'h80);
    localparam logic [TT_W-1:0] TT_SPILL_H = TT_W'(8'hBF);
    localparam logic [TT_W-1:0] TT_FILL_L  = TT_W'(8'hC0);
    localparam logic [TT_W-1:0] TT_FILL_H  = TT_W'(8'hFF);
    localparam logic [CWP_W-1:0] TOP_WIN   = CWP_W'(NWIN - 1);

    logic [SUM_W-1:0] spill_raw;
    logic [CWP_W-1:0] spill_win;
    logic [CWP_W-1:0] inc_win;
    logic [CWP_W-1:0] dec_win;

    assign spill_raw = SUM_W'(cwp_i) + SUM_W'(cansave_i) + SUM_W'(2);

    generate
        if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
            assign spill_win = spill_raw[CWP_W-1:0];
        end else begin : g_mod
            logic [SUM_W-1:0] spill_mod;
            assign spill_mod = spill_raw % SUM_W'(NWIN);
            assign spill_win = spill_mod[CWP_W-1:0];
        end
    endgenerate

    assign inc_win = (cwp_i >= TOP_WIN) ? '0 : cwp_i + CWP_W'(1);
    assign dec_win = (cwp_i == '0) ? TOP_WIN : cwp_i - CWP_W'(1);

    always_comb begin
        if (tt_i == TT_CLEAN) begin
            cwp_o = inc_win;
        end else if ((tt_i >= TT_SPILL_L) && (tt_i <= TT_SPILL_H)) begin
            cwp_o = spill_win;
        end else if ((tt_i >= TT_FILL_L) && (tt_i <= TT_FILL_H)) begin
            cwp_o = dec_win;
        end else begin
            cwp_o = cwp_i;
        end
    end

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_entry_pkg::*;
#(
    parameter int  NWIN    = 8,
    parameter int  MAX_TL  = 6,
    parameter int  MAX_PTL = 2,
    parameter int  MAX_GL  = 3,
    parameter int  MAX_PGL = 2,
    parameter int  TT_W    = 9,
    parameter int  PS_W    = 12,
    parameter int  HS_W    = 12,
    localparam int TL_W    = $clog2(MAX_TL + 1),
    localparam int GL_W    = $clog2(MAX_GL + 1),
    localparam int CWP_W   = $clog2(NWIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [TT_W-1:0]  tt_i,
    input  logic [TL_W-1:0]  tl_i,
    input  logic [PS_W-1:0]  pstate_i,
    input  logic [HS_W-1:0]  hpstate_i,
    input  logic [GL_W-1:0]  gl_i,
    input  logic [CWP_W-1:0] cwp_i,
    input  logic [CWP_W-1:0] cansave_i,
    output logic [TL_W-1:0]  tl_o,
    output logic [TT_W-1:0]  tt_o,
    output logic [GL_W-1:0]  gl_o,
    output logic [PS_W-1:0]  pstate_o,
    output logic [HS_W-1:0]  hpstate_o,
    output logic [CWP_W-1:0] cwp_o,
    output logic [1:0]       dest_o,
    output logic             done_o
);

    typedef struct packed {
        logic [TL_W-1:0]  tl;
        logic [TT_W-1:0]  tt;
        logic [GL_W-1:0]  gl;
        logic [PS_W-1:0]  ps;
        logic [HS_W-1:0]  hs;
        logic [CWP_W-1:0] cwp;
        trap_dest_e       dest;
        logic             done;
    } entry_state_t;

    entry_state_t st_d, st_q;

    run_mode_e        mode;
    trap_dest_e       dest;
    logic [TL_W-1:0]  tl_next;
    logic [GL_W-1:0]  gl_priv_next;
    logic [GL_W-1:0]  gl_hyp_next;
    logic [CWP_W-1:0] cwp_next;

    trap_dispatch #(
        .TT_W    (TT_W),
        .TL_W    (TL_W),
        .MAX_TL  (MAX_TL),
        .MAX_PTL (MAX_PTL)
    ) u_dispatch (
        .tt_i       (tt_i),
        .tl_i       (tl_i),
        .ps_priv_i  (pstate_i[PS_PRIV_BIT]),
        .hs_hpriv_i (hpstate_i[HS_HPRIV_BIT]),
        .hs_red_i   (hpstate_i[HS_RED_BIT]),
        .mode_o     (mode),
        .dest_o     (dest)
    );

    trap_level_sat #(.W(TL_W), .LIMIT(MAX_TL)) u_tl_sat (
        .val_i (tl_i),
        .val_o (tl_next)
    );

    trap_level_sat #(.W(GL_W), .LIMIT(MAX_PGL)) u_gl_priv_sat (
        .val_i (gl_i),
        .val_o (gl_priv_next)
    );

    trap_level_sat #(.W(GL_W), .LIMIT(MAX_GL)) u_gl_hyp_sat (
        .val_i (gl_i),
        .val_o (gl_hyp_next)
    );

    trap_window_adj #(
        .NWIN  (NWIN),
        .TT_W  (TT_W),
        .CWP_W (CWP_W)
    ) u_window (
        .tt_i      (tt_i),
        .cwp_i     (cwp_i),
        .cansave_i (cansave_i),
        .cwp_o     (cwp_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (req_i) begin
            st_d.done = 1'b1;
            st_d.dest = dest;
            if (dest == DEST_ERR) begin
                st_d.tl  = tl_i;
                st_d.gl  = gl_i;
                st_d.ps  = pstate_i;
                st_d.hs  = hpstate_i;
                st_d.cwp = cwp_i;
            end else begin
                st_d.tl  = tl_next;
                st_d.tt  = tt_i;
                st_d.cwp = cwp_next;
                st_d.gl  = (dest == DEST_PRIV) ? gl_priv_next : gl_hyp_next;
                st_d.ps  = pstate_i;
                st_d.ps[PS_ENTRY_BIT] = 1'b1;
                st_d.ps[PS_AM_BIT]    = 1'b0;
                st_d.ps[PS_PRIV_BIT]  = (dest == DEST_PRIV);
                st_d.hs  = hpstate_i;
                if (dest != DEST_PRIV) begin
                    st_d.hs[HS_HPRIV_BIT] = 1'b1;
                    st_d.hs[HS_RED_BIT]   = (dest == DEST_RED);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tl_o      = st_q.tl;
    assign tt_o      = st_q.tt;
    assign gl_o      = st_q.gl;
    assign pstate_o  = st_q.ps;
    assign hpstate_o = st_q.hs;
    assign cwp_o     = st_q.cwp;
    assign dest_o    = st_q.dest;
    assign done_o    = st_q.done;

    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> done_o); // R10
    AST_NO_DONE_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!done_o && $stable(tl_o) && $stable(cwp_o))); // R10
    AST_ERR_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && tl_i == TL_W'(MAX_TL) && !hpstate_i[HS_RED_BIT])
        |=> (dest_o == DEST_ERR && tl_o == $past(tl_i) && gl_o == $past(gl_i))); // R2
    AST_TL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dest_o != DEST_ERR) |-> (int'(tl_o) <= MAX_TL)); // R5
    AST_GL_PRIV_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dest_o == DEST_PRIV) |-> (int'(gl_o) <= MAX_PGL)); // R6
    AST_PRIV_ENTRY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dest_o == DEST_PRIV) |-> (pstate_o[PS_PRIV_BIT] && !pstate_o[PS_AM_BIT])); // R7
    AST_RED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && hpstate_i[HS_RED_BIT]) |=> (dest_o == DEST_RED && hpstate_o[HS_RED_BIT])); // R1
    AST_CWP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (int'(cwp_o) < NWIN)); // R9

endmodule

// File: tb/trap_entry_ctrl_bench.sv
module trap_entry_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [8:0]  tt = '0;
    logic [2:0]  tl = '0;
    logic [11:0] ps = '0;
    logic [11:0] hs = '0;
    logic [1:0]  gl = '0;
    logic [2:0]  cwp = '0;
    logic [2:0]  cs = '0;
    logic [2:0]  tl_o;
    logic [8:0]  tt_o;
    logic [1:0]  gl_o;
    logic [11:0] ps_o;
    logic [11:0] hs_o;
    logic [2:0]  cwp_o;
    logic [1:0]  dest_o;
    logic        done_o;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    trap_entry_ctrl u_trap_entry_ctrl (
        .clk (clk), .rst_n (rst_n), .req_i (req), .tt_i (tt), .tl_i (tl),
        .pstate_i (ps), .hpstate_i (hs), .gl_i (gl), .cwp_i (cwp), .cansave_i (cs),
        .tl_o (tl_o), .tt_o (tt_o), .gl_o (gl_o), .pstate_o (ps_o),
        .hpstate_o (hs_o), .cwp_o (cwp_o), .dest_o (dest_o), .done_o (done_o)
    );

    task automatic chk(string rq, string what, int act, int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic fire(int t_tt, int t_tl, int t_ps, int t_hs, int t_gl, int t_cwp, int t_cs);
        @(negedge clk);
        tt = 9'(t_tt); tl = 3'(t_tl); ps = 12'(t_ps); hs = 12'(t_hs);
        gl = 2'(t_gl); cwp = 3'(t_cwp); cs = 3'(t_cs);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic expect_all(string rq, int d, int e_tl, int e_tt, int e_gl,
                              int e_ps, int e_hs, int e_cwp);
        chk("R10", "done", int'(done_o), 1);
        chk(rq, "dest", int'(dest_o), d);
        chk(rq, "tl", int'(tl_o), e_tl);
        chk(rq, "tt", int'(tt_o), e_tt);
        chk(rq, "gl", int'(gl_o), e_gl);
        chk(rq, "pstate", int'(ps_o), e_ps);
        chk(rq, "hpstate", int'(hs_o), e_hs);
        chk(rq, "cwp", int'(cwp_o), e_cwp);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R11", "done", int'(done_o), 0);
        chk("R11", "tl", int'(tl_o), 0);
        chk("R11", "pstate", int'(ps_o), 0);
        chk("R11", "dest", int'(dest_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_user_clean();   // R4 R9: user -> privileged, clean window wraps
        fire(9'h024, 0, 12'h000, 12'h000, 0, 7, 3);
        expect_all("R9", 0, 1, 9'h024, 1, 12'h014, 12'h000, 0);
    endtask

    task automatic t_priv_high_tt(); // R4 R7 R8: privileged, tt 400 -> hyper
        fire(9'h190, 1, 12'h00C, 12'h000, 1, 2, 3);
        expect_all("R4", 1, 2, 9'h190, 2, 12'h010, 12'h004, 2);
    endtask

    task automatic t_priv_low_tt();  // R4 R6: tt 383 stays privileged, GL capped at 2
        fire(9'h17F, 1, 12'h006, 12'h000, 2, 5, 0);
        expect_all("R6", 0, 2, 9'h17F, 2, 12'h016, 12'h000, 5);
    endtask

    task automatic t_hyp_spill();    // R4 R6 R9: hyper mode, spill adds CANSAVE+2
        fire(9'h085, 2, 12'h002, 12'h004, 3, 6, 4);
        expect_all("R9", 1, 3, 9'h085, 3, 12'h012, 12'h004, 4);
    endtask

    task automatic t_red_bit();      // R1 R8 R9: red bit set, fill wraps down
        fire(9'h0C3, 0, 12'h000, 12'h020, 0, 0, 0);
        expect_all("R1", 2, 1, 9'h0C3, 1, 12'h010, 12'h024, 7);
    endtask

    task automatic t_red_level();    // R1 R5: TL = MAX_TL-1
        fire(9'h010, 5, 12'h008, 12'h000, 2, 3, 1);
        expect_all("R1", 2, 6, 9'h010, 3, 12'h010, 12'h024, 3);
    endtask

    task automatic t_error();        // R2: nothing updated, tt kept from prior trap
        fire(9'h024, 6, 12'h0FF, 12'h004, 1, 4, 2);
        expect_all("R2", 3, 6, 9'h010, 1, 12'h0FF, 12'h004, 4);
    endtask

    task automatic t_watchdog_priv(); // R3: privileged at TL 3
        fire(9'h020, 3, 12'h004, 12'h000, 1, 1, 0);
        expect_all("R3", 1, 4, 9'h020, 2, 12'h010, 12'h004, 1);
    endtask

    task automatic t_watchdog_user(); // R3: user at TL 4
        fire(9'h041, 4, 12'h000, 12'h000, 0, 2, 0);
        expect_all("R3", 1, 5, 9'h041, 1, 12'h010, 12'h004, 2);
    endtask

    task automatic t_user_high_tt(); // R4: user mode never goes hyper on type
        fire(9'h1A0, 0, 12'h002, 12'h000, 0, 1, 5);
        expect_all("R4", 0, 1, 9'h1A0, 1, 12'h016, 12'h000, 1);
    endtask

    task automatic t_spill_wrap();   // R9: 7+7+2 wraps to 0
        fire(9'h0BF, 1, 12'h000, 12'h000, 1, 7, 7);
        expect_all("R9", 0, 2, 9'h0BF, 2, 12'h014, 12'h000, 0);
    endtask

    task automatic t_gl_cap();       // R6 R8: GL 3 to privileged becomes 2, hpstate untouched
        fire(9'h030, 0, 12'h004, 12'h800, 3, 3, 0);
        expect_all("R6", 0, 1, 9'h030, 2, 12'h014, 12'h800, 3);
    endtask

    task automatic t_hold();         // R10: no request, new inputs ignored
        @(negedge clk);
        tt = 9'h0C0; tl = 3'd2; ps = 12'hFFF; hs = 12'h004; gl = 2'd0; cwp = 3'd6;
        repeat (3) @(negedge clk);
        chk("R10", "done low", int'(done_o), 0);
        chk("R10", "tl hold", int'(tl_o), 1);
        chk("R10", "gl hold", int'(gl_o), 2);
        chk("R10", "pstate hold", int'(ps_o), 12'h014);
        chk("R10", "cwp hold", int'(cwp_o), 3);
        chk("R5", "tt hold", int'(tt_o), 9'h030);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_user_clean();
        t_priv_high_tt();
        t_priv_low_tt();
        t_hyp_spill();
        t_red_bit();
        t_red_level();
        t_error();
        t_watchdog_priv();
        t_watchdog_user();
        t_user_high_tt();
        t_spill_wrap();
        t_gl_cap();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule